// File: doc/BRIEF.md
# Serial Port Register File

This block is the processor-facing side of a 16550A-compatible serial port. A host reaches it through an eight-byte window with single-cycle byte reads and writes. Behind the window sit the line, modem, interrupt-enable, scratch and divisor registers, plus two 64-entry byte queues: one for outgoing characters and one for incoming characters. Serialisation, baud timing and modem pins live elsewhere. Outgoing characters leave on a ready/valid byte stream. Incoming characters arrive on a valid-only byte stream, which also carries a one-cycle strobe that signals a line break.

A single level-sensitive interrupt output reports two causes: unread receive data and an empty transmit side. The interrupt identification register can show both causes at once. Software can turn on an internal loopback, in which characters written for transmission are placed directly in the receive queue. The divisor latch is only stored and read back.

Read data is combinational from the current state. The side effects of a read, such as popping a received byte or consuming a break, take place at the clock edge that ends the read cycle.

Top module: `ser_port_regs`

## Requirements
- R1: After reset, offset 2 reads 0xC1, offset 5 reads 0x60, offset 6 reads 0xB0, offset 4 reads 0x08, offset 1 reads 0x00, and irq is low.
- R2: While bit 7 of the line control register (offset 3) is set, offsets 0 and 1 read and write the low and high divisor bytes. A write to offset 0 then sends nothing on the transmit stream, and offset 1 no longer shows the interrupt-enable value.
- R3: A write to offset 1 (divisor access off) keeps only bits 3:0. Bits 7:4 always read as zero.
- R4: Offset 2 reads the interrupt code ORed with 0xC0. The code is 0x01 when no cause is active. Otherwise it is the OR of 0x04 (enable bit 0 set and data-ready set) and 0x02 (enable bit 1 set and transmitter-empty set). irq is high exactly when the code is not 0x01.
- R5: The line status at offset 5 uses bit 0 for data-ready, bit 4 for break, bit 5 for holding-empty and bit 6 for transmitter-empty. With enable bit 1 set, a transmit write (offset 0, not loopback) queues the byte and clears bit 6. Queued bytes leave the stream in write order. When the queue empties, bits 5 and 6 are set again.
- R6: With enable bit 1 set, bit 5 clears when a write brings the transmit queue to 32 entries. A write to a full 64-entry queue is dropped and clears bits 5 and 6.
- R7: While enable bit 1 is clear, bits 5 and 6 read as set even when bytes are still queued.
- R8: With bit 4 of offset 4 set (loopback), transmit writes go into the receive queue and set data-ready. The external receive stream and the break strobe are ignored.
- R9: Up to 64 received bytes are kept in arrival order, and further bytes are dropped. Reading offset 0 returns and removes the oldest byte. Reading the last byte clears data-ready. A read of an empty queue returns 0x00 and changes nothing.
- R10: A break strobe sets status bits 4 and 0. The next data read returns 0x00 and clears only bit 4. Queued bytes stay in place.
- R11: Writes to offsets 5 and 6 are ignored. Offset 7 stores and returns any byte.
- R12: An external receive byte arriving in the same cycle as a data read is kept, and the read still returns the older byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 3 | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, side effects at end of cycle |
| bus_rdata | output | 8 | Read data |
| irq | output | 1 | Level interrupt |
| tx_valid | output | 1 | Transmit byte available |
| tx_ready | input | 1 | Transmit consumer ready |
| tx_data | output | 8 | Transmit byte |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| rx_break | input | 1 | Break strobe |

## Verification
The receive queue can be written and read in the same cycle: an incoming byte from the stream can coincide with a host read that removes the last stored byte. The bench provokes this by holding one byte in the queue and then raising rx_valid and the data read together. It judges the result by checking that the read returned the old byte, that data-ready stays set afterwards, and that the next read returns the new byte. A pointer reset on empty must not discard the byte that arrived in that same cycle.

// File: rtl/ser_port_pkg.sv
package ser_port_pkg;
  localparam int BYTE_W = 8;
  typedef logic [BYTE_W-1:0] byte_t;

  typedef enum logic [2:0] {
    OFS_DATA    = 3'd0,
    OFS_IEN     = 3'd1,
    OFS_ISTAT   = 3'd2,
    OFS_LINE    = 3'd3,
    OFS_MODEM   = 3'd4,
    OFS_LSTAT   = 3'd5,
    OFS_MSTAT   = 3'd6,
    OFS_SCRATCH = 3'd7
  } ofs_e;

  localparam int    LINE_DIV_BIT   = 7;
  localparam int    MODEM_LOOP_BIT = 4;
  localparam byte_t MODEM_RST      = 8'h08;
  localparam byte_t MSTAT_FIXED    = 8'hB0;
  localparam byte_t ISTAT_IDLE     = 8'h01;
  localparam byte_t ISTAT_TYPE     = 8'hC0;

  // interrupt identification code from the two active causes
  function automatic byte_t istat_code(input logic rx_cause, input logic tx_cause);
    if (!rx_cause && !tx_cause) return ISTAT_IDLE;
    return {5'b0, rx_cause, tx_cause, 1'b0};
  endfunction

  // line status byte from its flags
  function automatic byte_t lstat_pack(input logic temt, input logic thre,
                                       input logic brk, input logic rdy);
    return {1'b0, temt, thre, brk, 3'b000, rdy};
  endfunction
endpackage

// File: rtl/ser_fifo.sv
module ser_fifo #(
  parameter int DEPTH = 64,
  parameter int W     = 8,
  localparam int PW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [W-1:0]  din,
  input  logic          pop,
  output logic [W-1:0]  dout,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          push_ok,
  output logic          pop_ok
);
  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wr_ptr, rd_ptr;

  function automatic logic [PW-1:0] step(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign dout    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (pop_ok && !push_ok && count == CW'(1)) begin
        wr_ptr <= '0;
        rd_ptr <= '0;
      end else begin
        if (push_ok) wr_ptr <= step(wr_ptr);
        if (pop_ok)  rd_ptr <= step(rd_ptr);
      end
      count <= count + CW'(push_ok) - CW'(pop_ok);
    end
  end
endmodule

// File: rtl/ser_irq_eval.sv
module ser_irq_eval
  import ser_port_pkg::*;
(
  input  logic [3:0] ien,
  input  logic       data_rdy,
  input  logic       tx_empty,
  output byte_t      istat,
  output logic       irq
);
  logic rx_cause, tx_cause;
  assign rx_cause = ien[0] && data_rdy;
  assign tx_cause = ien[1] && tx_empty;
  assign istat    = istat_code(rx_cause, tx_cause);
  assign irq      = rx_cause || tx_cause;
endmodule

// File: rtl/ser_port_regs.sv
module ser_port_regs
  import ser_port_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata,
  output logic       irq,
  output logic       tx_valid,
  input  logic       tx_ready,
  output logic [7:0] tx_data,
  input  logic       rx_valid,
  input  logic [7:0] rx_data,
  input  logic       rx_break
);
  localparam int CW   = $clog2(FIFO_DEPTH + 1);
  localparam int HALF = FIFO_DEPTH / 2;

  byte_t      div_lo, div_hi, fifo_ctl, line_ctl, modem_ctl, scratch;
  logic [3:0] ien;
  logic       temt, thre, brk;

  ofs_e  ofs;
  logic  div_on, loop_on;
  assign ofs     = ofs_e'(bus_addr);
  assign div_on  = line_ctl[LINE_DIV_BIT];
  assign loop_on = modem_ctl[MODEM_LOOP_BIT];

  // named events
  logic data_wr, data_rd, tx_wr_ev, lb_wr_ev, brk_rd_ev, rx_rd_ev, ext_push_ev, brk_set_ev;
  assign data_wr     = bus_wr && ofs == OFS_DATA && !div_on;
  assign data_rd     = bus_rd && ofs == OFS_DATA && !div_on;
  assign tx_wr_ev    = data_wr && !loop_on;
  assign lb_wr_ev    = data_wr && loop_on;
  assign brk_rd_ev   = data_rd && brk;
  assign rx_rd_ev    = data_rd && !brk;
  assign ext_push_ev = rx_valid && !loop_on;
  assign brk_set_ev  = rx_break && !loop_on;

  // transmit queue
  byte_t         tx_dout;
  logic [CW-1:0] tx_cnt;
  logic          tx_full, tx_empty_q, tx_push_ok, tx_pop_ok;
  logic [CW-1:0] tx_cnt_nxt;

  ser_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_tx_q (
    .clk(clk), .rst_n(rst_n),
    .push(tx_wr_ev), .din(bus_wdata),
    .pop(tx_valid && tx_ready), .dout(tx_dout),
    .count(tx_cnt), .full(tx_full), .empty(tx_empty_q),
    .push_ok(tx_push_ok), .pop_ok(tx_pop_ok)
  );

  assign tx_valid   = !tx_empty_q;
  assign tx_data    = tx_dout;
  assign tx_cnt_nxt = tx_cnt + CW'(tx_push_ok) - CW'(tx_pop_ok);

  // receive queue
  byte_t         rx_dout;
  logic [CW-1:0] rx_cnt;
  logic          rx_full, rx_empty_q, rx_push_ok, rx_pop_ok;
  logic          data_rdy;

  ser_fifo #(.DEPTH(FIFO_DEPTH), .W(BYTE_W)) u_rx_q (
    .clk(clk), .rst_n(rst_n),
    .push(lb_wr_ev || ext_push_ev), .din(lb_wr_ev ? bus_wdata : rx_data),
    .pop(rx_rd_ev), .dout(rx_dout),
    .count(rx_cnt), .full(rx_full), .empty(rx_empty_q),
    .push_ok(rx_push_ok), .pop_ok(rx_pop_ok)
  );

  assign data_rdy = !rx_empty_q || brk;

  // interrupt
  byte_t istat;
  ser_irq_eval u_irq (
    .ien(ien), .data_rdy(data_rdy), .tx_empty(temt),
    .istat(istat), .irq(irq)
  );

  // control registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      div_lo    <= '0;
      div_hi    <= '0;
      fifo_ctl  <= '0;
      line_ctl  <= '0;
      modem_ctl <= MODEM_RST;
      scratch   <= '0;
      ien       <= '0;
    end else if (bus_wr) begin
      unique case (ofs)
        OFS_DATA:    if (div_on) div_lo <= bus_wdata;
        OFS_IEN:     if (div_on) div_hi <= bus_wdata; else ien <= bus_wdata[3:0];
        OFS_ISTAT:   fifo_ctl  <= bus_wdata;
        OFS_LINE:    line_ctl  <= bus_wdata;
        OFS_MODEM:   modem_ctl <= bus_wdata;
        OFS_SCRATCH: scratch   <= bus_wdata;
        default: ;
      endcase
    end
  end

  // transmit status flags
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      temt <= 1'b1;
      thre <= 1'b1;
    end else if (!ien[1]) begin
      temt <= 1'b1;
      thre <= 1'b1;
    end else if (tx_wr_ev && tx_full) begin
      temt <= 1'b0;
      thre <= 1'b0;
    end else if (tx_push_ok) begin
      temt <= 1'b0;
      if (tx_cnt_nxt == CW'(HALF)) thre <= 1'b0;
    end else if (tx_pop_ok && tx_cnt == CW'(1)) begin
      temt <= 1'b1;
      thre <= 1'b1;
    end
  end

  // break indicator
  always_ff @(posedge clk) begin
    if (!rst_n)          brk <= 1'b0;
    else if (brk_set_ev) brk <= 1'b1;
    else if (brk_rd_ev)  brk <= 1'b0;
  end

  // read mux
  always_comb begin
    unique case (ofs)
      OFS_DATA:    bus_rdata = div_on ? div_lo : ((brk || rx_empty_q) ? 8'h00 : rx_dout);
      OFS_IEN:     bus_rdata = div_on ? div_hi : {4'b0, ien};
      OFS_ISTAT:   bus_rdata = istat | ISTAT_TYPE;
      OFS_LINE:    bus_rdata = line_ctl;
      OFS_MODEM:   bus_rdata = modem_ctl;
      OFS_LSTAT:   bus_rdata = lstat_pack(temt, thre, brk, data_rdy);
      OFS_MSTAT:   bus_rdata = MSTAT_FIXED;
      default:     bus_rdata = scratch;
    endcase
  end
endmodule

// File: rtl/ser_port_regs_chk.sv
module ser_port_regs_chk #(
  parameter int FIFO_DEPTH = 64,
  localparam int CW = $clog2(FIFO_DEPTH + 1)
) (
  input logic          clk,
  input logic          rst_n,
  input logic [2:0]    bus_addr,
  input logic          bus_rd,
  input logic          bus_wr,
  input logic [7:0]    bus_rdata,
  input logic          irq,
  input logic          tx_valid,
  input logic          tx_ready,
  input logic [7:0]    tx_data,
  input logic          rx_valid,
  input logic [3:0]    ien,
  input logic          div_on,
  input logic          loop_on,
  input logic [CW-1:0] tx_cnt,
  input logic [CW-1:0] rx_cnt
);
  p_istat_type_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd2) |-> bus_rdata[7:6] == 2'b11);

  p_irq_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd2) |-> (irq == (bus_rdata != 8'hC1)));

  p_no_cause_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (ien[1:0] == 2'b00) |-> !irq);

  p_ien_upper_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd1 && !div_on) |-> bus_rdata[7:4] == 4'h0);

  p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  p_flag_order_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd5) |-> !(bus_rdata[6] && !bus_rdata[5]));

  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tx_cnt) <= FIFO_DEPTH) && (int'(rx_cnt) <= FIFO_DEPTH));

  p_loop_ignore_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (loop_on && rx_valid && !bus_wr && !bus_rd) |=> rx_cnt == $past(rx_cnt));

  p_empty_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 3'd0 && !div_on && rx_cnt == '0 && !rx_valid && !bus_wr)
      |=> rx_cnt == '0);
endmodule

bind ser_port_regs ser_port_regs_chk #(.FIFO_DEPTH(FIFO_DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
  .bus_rdata(bus_rdata), .irq(irq), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .tx_data(tx_data), .rx_valid(rx_valid), .ien(ien), .div_on(div_on),
  .loop_on(loop_on), .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/test_ser_port_regs.sv
`timescale 1ns/100ps
module test_ser_port_regs;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] bus_addr = '0;
  logic       bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic       irq, tx_valid, tx_ready = 1'b0;
  logic [7:0] tx_data;
  logic       rx_valid = 1'b0, rx_break = 1'b0;
  logic [7:0] rx_data = '0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [7:0] tx_log [0:127];
  int tx_n = 0;

  always #2 clk = ~clk;

  ser_port_regs i_ser_port_regs (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_break(rx_break)
  );

  // record completed transmit handshakes
  always @(negedge clk) begin
    #1;
    if (rst_n && tx_valid && tx_ready && tx_n < 128) begin
      tx_log[tx_n] = tx_data;
      tx_n++;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic rx_push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rd(3'd2, v); chk("R1 istat", v, 8'hC1);
    rd(3'd5, v); chk("R1 lstat", v, 8'h60);
    rd(3'd6, v); chk("R1 mstat", v, 8'hB0);
    rd(3'd4, v); chk("R1 modem", v, 8'h08);
    rd(3'd1, v); chk("R1 ien", v, 8'h00);
    chk("R1 irq", irq, 0);
  endtask

  task automatic t_divisor;
    logic [7:0] v;
    wr(3'd1, 8'h05);
    wr(3'd3, 8'h80);
    wr(3'd0, 8'h12);
    wr(3'd1, 8'h34);
    rd(3'd0, v); chk("R2 div low", v, 8'h12);
    rd(3'd1, v); chk("R2 div high", v, 8'h34);
    chk("R2 no tx", tx_valid, 0);
    wr(3'd3, 8'h03);
    rd(3'd1, v); chk("R2 ien back", v, 8'h05);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_ien_mask;
    logic [7:0] v;
    wr(3'd1, 8'hFF);
    rd(3'd1, v); chk("R3 ien mask", v, 8'h0F);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_istat;
    logic [7:0] v;
    wr(3'd1, 8'h02);
    rd(3'd2, v); chk("R4 tx cause", v, 8'hC2);
    chk("R4 irq tx", irq, 1);
    rx_push(8'h41);
    wr(3'd1, 8'h03);
    rd(3'd2, v); chk("R4 both causes", v, 8'hC6);
    wr(3'd1, 8'h01);
    rd(3'd2, v); chk("R4 rx cause", v, 8'hC4);
    rd(3'd0, v);
    rd(3'd2, v); chk("R4 none", v, 8'hC1);
    chk("R4 irq low", irq, 0);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_tx_basic;
    logic [7:0] v;
    tx_ready = 1'b0;
    wr(3'd1, 8'h02);
    wr(3'd0, 8'hA1);
    wr(3'd0, 8'hB2);
    rd(3'd5, v); chk("R5 temt clear", v, 8'h20);
    wr(3'd1, 8'h00);
    rd(3'd5, v); chk("R7 forced drained", v, 8'h60);
    tx_n = 0;
    @(negedge clk); tx_ready = 1'b1;
    idle(6);
    chk("R5 tx count", tx_n, 2);
    chk("R5 tx first", tx_log[0], 8'hA1);
    chk("R5 tx second", tx_log[1], 8'hB2);
    wr(3'd1, 8'h02);
    wr(3'd0, 8'hC3);
    idle(4);
    rd(3'd5, v); chk("R5 refill on drain", v, 8'h60);
    chk("R5 third byte", tx_log[2], 8'hC3);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_tx_half_full;
    logic [7:0] v;
    int errs;
    @(negedge clk); tx_ready = 1'b0;
    wr(3'd1, 8'h02);
    for (int i = 0; i < 31; i++) wr(3'd0, 8'(i));
    rd(3'd5, v); chk("R6 below half", v, 8'h20);
    wr(3'd0, 8'd31);
    rd(3'd5, v); chk("R6 at half", v, 8'h00);
    for (int i = 32; i < 64; i++) wr(3'd0, 8'(i));
    wr(3'd0, 8'hEE);
    rd(3'd5, v); chk("R6 full drop", v, 8'h00);
    tx_n = 0;
    @(negedge clk); tx_ready = 1'b1;
    idle(72);
    chk("R6 drained count", tx_n, 64);
    errs = 0;
    for (int i = 0; i < 64; i++) if (tx_log[i] !== 8'(i)) errs++;
    chk("R5 order", errs, 0);
    rd(3'd2, v); chk("R4 tx empty cause", v, 8'hC2);
    wr(3'd1, 8'h00);
  endtask

  task automatic t_loopback;
    logic [7:0] v;
    tx_n = 0;
    wr(3'd4, 8'h18);
    wr(3'd0, 8'hA5);
    rx_push(8'h77);
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    idle(2);
    chk("R8 no tx", tx_n, 0);
    rd(3'd5, v); chk("R8 ready", v, 8'h61);
    rd(3'd0, v); chk("R8 looped byte", v, 8'hA5);
    rd(3'd5, v); chk("R8 ext ignored", v, 8'h60);
    wr(3'd4, 8'h08);
  endtask

  task automatic t_rx_queue;
    logic [7:0] v;
    int errs;
    rx_push(8'h10); rx_push(8'h20);
    rd(3'd5, v); chk("R9 ready", v, 8'h61);
    rd(3'd0, v); chk("R9 first", v, 8'h10);
    rd(3'd0, v); chk("R9 second", v, 8'h20);
    rd(3'd5, v); chk("R9 ready clear", v, 8'h60);
    rd(3'd0, v); chk("R9 empty read", v, 8'h00);
    rd(3'd5, v); chk("R9 empty unchanged", v, 8'h60);
    for (int i = 0; i < 66; i++) rx_push(8'(i + 1));
    errs = 0;
    for (int i = 0; i < 64; i++) begin
      rd(3'd0, v);
      if (v !== 8'(i + 1)) errs++;
    end
    chk("R9 overflow order", errs, 0);
    rd(3'd5, v); chk("R9 excess dropped", v, 8'h60);
  endtask

  task automatic t_break;
    logic [7:0] v;
    rx_push(8'h55);
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    rd(3'd5, v); chk("R10 flags", v, 8'h71);
    rd(3'd0, v); chk("R10 zero read", v, 8'h00);
    rd(3'd5, v); chk("R10 bi only", v, 8'h61);
    rd(3'd0, v); chk("R10 byte kept", v, 8'h55);
    @(negedge clk); rx_break = 1'b1;
    @(negedge clk); rx_break = 1'b0;
    rd(3'd0, v); chk("R10 empty break", v, 8'h00);
    rd(3'd5, v); chk("R10 ready off", v, 8'h60);
  endtask

  task automatic t_ignored;
    logic [7:0] v;
    wr(3'd5, 8'h00);
    rd(3'd5, v); chk("R11 lstat write", v, 8'h60);
    wr(3'd6, 8'h00);
    rd(3'd6, v); chk("R11 mstat write", v, 8'hB0);
    wr(3'd7, 8'h5A);
    rd(3'd7, v); chk("R11 scratch", v, 8'h5A);
  endtask

  task automatic t_same_cycle;
    logic [7:0] v;
    rx_push(8'h11);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = 8'h22; bus_addr = 3'd0; bus_rd = 1'b1;
    #1 v = bus_rdata;
    @(negedge clk);
    rx_valid = 1'b0; bus_rd = 1'b0;
    chk("R12 old byte", v, 8'h11);
    rd(3'd5, v); chk("R12 still ready", v, 8'h61);
    rd(3'd0, v); chk("R12 new byte", v, 8'h22);
    rd(3'd5, v); chk("R12 drained", v, 8'h60);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_divisor();
    t_ien_mask();
    t_istat();
    t_tx_basic();
    t_tx_half_full();
    t_loopback();
    t_rx_queue();
    t_break();
    t_ignored();
    t_same_cycle();
    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule